// File: doc/BRIEF.md
# Chip-Select Timing Sequencer

This block owns the active-low chip-select lines of a serial flash-style master and places programmable guard times around every clock burst. A sequencer asks for a transaction with a start request, reports unit boundaries and the end of each transfer (with a flag saying whether the transfer closes the transaction), and may issue a stop command. The block answers with a chip-select on one of two lines, a clock-enable that gates the serial clock, and a busy flag. Clock generation and data movement live elsewhere.

Four 4-bit delays, all counted in system clock cycles, shape the transaction. The lead delay separates chip-select assertion from the first clock. The trail delay and the data-hold delay both run from the last clock, and chip-select is released only once the longer of the two has elapsed. The gap delay sets the minimum time chip-select stays high before it may be asserted again; busy covers this gap, and a start request that arrives during it is remembered and served when the gap ends.

A transfer that ends without the close flag leaves chip-select asserted with the clock stopped, so the next start request resumes clocking at once without a new lead delay. A stop command never cuts a unit short: it is held until the next unit boundary or transfer end, and when the clock is already parked it releases chip-select straight away.

Top module: `csq_top`

## Requirements
- R1: After reset both chip-select lines are high, the clock-enable is low and busy is low.
- R2: The timing word holds the lead delay in bits 3:0, the trail delay in bits 11:8, the data-hold delay in bits 19:16 and the gap delay in bits 27:24; every other bit has no effect on any output timing.
- R3: A start request in the idle state drives the selected chip-select low on the next clock edge, and the clock-enable rises lead+1 cycles after chip-select falls (a lead of 0 gives exactly one cycle).
- R4: The select input (0 picks cs_n bit 0, 1 picks cs_n bit 1) is sampled when chip-select is asserted; the other line stays high and later changes of the select input have no effect until the next assertion.
- R5: A transfer end with the close flag drops the clock-enable on the next edge and releases chip-select max(trail, hold)+1 cycles after the clock-enable falls.
- R6: A transfer end without the close flag drops the clock-enable but keeps chip-select low and busy high; a following start request raises the clock-enable on the next edge, with no lead delay.
- R7: A stop command during clocking does not stop the clock at once; the clock-enable stays high until the next unit-boundary strobe, after which chip-select is released as in R5.
- R8: A stop command while the clock is parked with chip-select held begins the release on the next edge, as in R5.
- R9: After chip-select rises, busy stays high for gap+1 cycles and then falls.
- R10: A start request arriving while chip-select is in its gap is held; chip-select is asserted again exactly gap+1 cycles after it rose.
- R11: The clock-enable is never high while every chip-select line is high, and at most one chip-select line is low at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_cfg | input | 32 | Packed lead, trail, hold and gap delays |
| cs_pick | input | 1 | Which chip-select line the next transaction uses |
| start_req | input | 1 | Begin a transaction or resume a parked one |
| unit_edge | input | 1 | Pulse at each unit boundary from the sequencer |
| xfer_end | input | 1 | Pulse when the current transfer finishes |
| close_flag | input | 1 | With xfer_end: release chip-select after this transfer |
| stop_cmd | input | 1 | Release chip-select at the next unit boundary |
| cs_n | output | 2 | Active-low chip-select lines |
| sclk_en | output | 1 | Gates the serial clock |
| busy | output | 1 | High from assertion until the gap has elapsed |

## Verification
The bench measures each delay in cycles with zero values, with the trail delay dominating and with the hold delay dominating, since a design that used only one of the two post-clock delays, or counted one cycle short, would release chip-select early. It sets every unused bit of the timing word to catch a field read from the wrong offset. It holds a stop command across several clock cycles to catch a design that cuts a unit in half, and issues a stop while parked to catch one that waits for a boundary that never comes. It also fires a start inside the gap, where a design that drops the request would stay idle and one that ignores the gap would reassert chip-select too soon.

// File: rtl/csq_pkg.sv
package csq_pkg;

  localparam int unsigned CSQ_DLY_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_RUN  = 3'd2,
    ST_PARK = 3'd3,
    ST_TAIL = 3'd4,
    ST_GAP  = 3'd5
  } csq_state_e;

endpackage

// File: rtl/csq_cfg_unpack.sv
module csq_cfg_unpack #(
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned DLY_W    = 4,
  parameter int unsigned N_FIELDS = 4,
  parameter int unsigned STRIDE   = 8
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [DLY_W-1:0] lead_dly,
  output logic [DLY_W-1:0] tail_dly,
  output logic [DLY_W-1:0] gap_dly
);

  localparam int unsigned F_LEAD  = 0;
  localparam int unsigned F_TRAIL = 1;
  localparam int unsigned F_HOLD  = 2;
  localparam int unsigned F_GAP   = 3;

  logic [DLY_W-1:0] fld [N_FIELDS];

  // one field per byte lane, low nibble used
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign fld[g] = cfg[g*STRIDE +: DLY_W];
  end

  assign lead_dly = fld[F_LEAD];
  assign gap_dly  = fld[F_GAP];
  // release waits for both the clock-to-release and the data-hold times
  assign tail_dly = (fld[F_TRAIL] > fld[F_HOLD]) ? fld[F_TRAIL] : fld[F_HOLD];

endmodule

// File: rtl/csq_timer.sv
module csq_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R9
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

  // R3
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
  import csq_pkg::*;
#(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             unit_edge,
  input  logic             xfer_end,
  input  logic             close_flag,
  input  logic             stop_cmd,
  input  logic             expired,
  input  logic [DLY_W-1:0] lead_dly,
  input  logic [DLY_W-1:0] tail_dly,
  input  logic [DLY_W-1:0] gap_dly,
  output logic             tmr_load,
  output logic [DLY_W-1:0] tmr_val,
  output logic             sel_capture,
  output logic             cs_active,
  output logic             sclk_en,
  output logic             busy
);

  csq_state_e state_q, state_d;
  logic stop_pend_q, stop_pend_d;
  logic start_pend_q, start_pend_d;
  logic cs_q, sclk_q, busy_q;
  logic stop_now;

  assign stop_now = stop_pend_q || stop_cmd;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d  = ST_LEAD;
          tmr_load = 1'b1;
          tmr_val  = lead_dly;
        end
      end
      ST_LEAD: begin
        if (expired) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (xfer_end && (close_flag || stop_now)) begin
          state_d  = ST_TAIL;
          tmr_load = 1'b1;
          tmr_val  = tail_dly;
        end else if (xfer_end) begin
          state_d = ST_PARK;
        end else if (unit_edge && stop_now) begin
          state_d  = ST_TAIL;
          tmr_load = 1'b1;
          tmr_val  = tail_dly;
        end
      end
      ST_PARK: begin
        if (stop_now) begin
          state_d  = ST_TAIL;
          tmr_load = 1'b1;
          tmr_val  = tail_dly;
        end else if (start_req) begin
          state_d = ST_RUN;
        end
      end
      ST_TAIL: begin
        if (expired) begin
          state_d  = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = gap_dly;
        end
      end
      ST_GAP: begin
        if (expired) begin
          if (start_pend_q || start_req) begin
            state_d  = ST_LEAD;
            tmr_load = 1'b1;
            tmr_val  = lead_dly;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    stop_pend_d = (stop_pend_q ||
                   (stop_cmd && (state_q == ST_LEAD || state_q == ST_RUN)))
                  && (state_d != ST_TAIL);
    start_pend_d = (start_pend_q ||
                    (start_req && (state_q == ST_TAIL || state_q == ST_GAP)))
                   && (state_d != ST_LEAD);
  end

  assign sel_capture = (state_d == ST_LEAD) && (state_q != ST_LEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      stop_pend_q  <= 1'b0;
      start_pend_q <= 1'b0;
      cs_q         <= 1'b0;
      sclk_q       <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      state_q      <= state_d;
      stop_pend_q  <= stop_pend_d;
      start_pend_q <= start_pend_d;
      cs_q         <= (state_d == ST_LEAD) || (state_d == ST_RUN) ||
                      (state_d == ST_PARK) || (state_d == ST_TAIL);
      sclk_q       <= (state_d == ST_RUN);
      busy_q       <= (state_d != ST_IDLE);
    end
  end

  assign cs_active = cs_q;
  assign sclk_en   = sclk_q;
  assign busy      = busy_q;

  // R11
  clk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> cs_q);

  // R3
  lead_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(cs_q));

  // R7
  clk_stops_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_q) && $past(state_q == ST_RUN)) |-> $past(xfer_end || unit_edge));

  // R5
  release_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> $past(!sclk_q));

  // R9
  idle_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!cs_q && $past(!cs_q)));

endmodule

// File: rtl/csq_select.sv
module csq_select #(
  parameter int unsigned N_CS  = 2,
  parameter int unsigned SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [SEL_W-1:0] pick,
  input  logic             cs_active,
  output logic [N_CS-1:0]  cs_n
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (capture) sel_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  for (genvar i = 0; i < N_CS; i++) begin : g_line
    assign cs_n[i] = !(cs_active && (sel_q == SEL_W'(i)));
  end

  // R11
  single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R4
  sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && $past(cs_active)) |-> $stable(cs_n));

endmodule

// File: rtl/csq_top.sv
module csq_top
  import csq_pkg::*;
#(
  parameter int unsigned CFG_W = 32,
  parameter int unsigned N_CS  = 2,
  parameter int unsigned SEL_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] timing_cfg,
  input  logic [SEL_W-1:0] cs_pick,
  input  logic             start_req,
  input  logic             unit_edge,
  input  logic             xfer_end,
  input  logic             close_flag,
  input  logic             stop_cmd,
  output logic [N_CS-1:0]  cs_n,
  output logic             sclk_en,
  output logic             busy
);

  localparam int unsigned DLY_W = CSQ_DLY_W;

  logic [DLY_W-1:0] lead_dly, tail_dly, gap_dly, tmr_val;
  logic tmr_load, expired, sel_capture, cs_active;

  csq_cfg_unpack #(.CFG_W(CFG_W), .DLY_W(DLY_W), .N_FIELDS(4), .STRIDE(8)) u_unpack (
    .cfg      (timing_cfg),
    .lead_dly (lead_dly),
    .tail_dly (tail_dly),
    .gap_dly  (gap_dly)
  );

  csq_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  csq_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .unit_edge   (unit_edge),
    .xfer_end    (xfer_end),
    .close_flag  (close_flag),
    .stop_cmd    (stop_cmd),
    .expired     (expired),
    .lead_dly    (lead_dly),
    .tail_dly    (tail_dly),
    .gap_dly     (gap_dly),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .sel_capture (sel_capture),
    .cs_active   (cs_active),
    .sclk_en     (sclk_en),
    .busy        (busy)
  );

  csq_select #(.N_CS(N_CS), .SEL_W(SEL_W)) u_select (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (sel_capture),
    .pick      (cs_pick),
    .cs_active (cs_active),
    .cs_n      (cs_n)
  );

endmodule

// File: tb/csq_top_test.sv
module csq_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] timing_cfg;
  logic [0:0]  cs_pick;
  logic        start_req, unit_edge, xfer_end, close_flag, stop_cmd;
  logic [1:0]  cs_n;
  logic        sclk_en, busy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  csq_top uut (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .cs_pick(cs_pick),
    .start_req(start_req), .unit_edge(unit_edge), .xfer_end(xfer_end),
    .close_flag(close_flag), .stop_cmd(stop_cmd),
    .cs_n(cs_n), .sclk_en(sclk_en), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <=20000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk_cfg(int l, int t, int h, int g);
    return {4'h0, 4'(g), 4'h0, 4'(h), 4'h0, 4'(t), 4'h0, 4'(l)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sig: 0 sclk_en, 1 any chip-select low, 2 busy. Current negedge counts as 1.
  task automatic wait_for(int sig, logic val, output int n);
    logic cur;
    n = 1;
    for (int k = 0; k < 60; k++) begin
      cur = (sig == 0) ? sclk_en : (sig == 1) ? (cs_n != 2'b11) : busy;
      if (cur == val) break;
      @(negedge clk);
      n = n + 1;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic end_close();
    xfer_end = 1'b1; close_flag = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0; close_flag = 1'b0;
  endtask

  // full transaction with measured lead, release and gap
  task automatic t_full(string name, logic [31:0] cfg, int l, int tl, int g, logic pk);
    int n;
    timing_cfg = cfg;
    cs_pick = pk;
    pulse(start_req);
    chk({name, " R4 line"}, cs_n, pk ? 2'b01 : 2'b10);
    chk({name, " R3 busy"}, busy, 1);
    wait_for(0, 1'b1, n);
    chk({name, " R3 lead"}, n, l + 2);
    chk({name, " R11 cs with clk"}, (cs_n != 2'b11), 1);
    repeat (3) @(negedge clk);
    end_close();
    chk({name, " R5 clk off"}, sclk_en, 0);
    wait_for(1, 1'b0, n);
    chk({name, " R5 release"}, n, tl + 2);
    wait_for(2, 1'b0, n);
    chk({name, " R9 gap"}, n, g + 2);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 2'b11);
    chk("R1 sclk_en", sclk_en, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_park();
    int n;
    timing_cfg = mk_cfg(2, 1, 1, 1);
    cs_pick = 1'b0;
    pulse(start_req);
    wait_for(0, 1'b1, n);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    chk("R6 clk off", sclk_en, 0);
    repeat (5) @(negedge clk);
    chk("R6 cs held", cs_n, 2'b10);
    chk("R6 busy", busy, 1);
    pulse(start_req);
    chk("R6 resume no lead", sclk_en, 1);
    end_close();
    wait_for(2, 1'b0, n);
  endtask

  task automatic t_stop();
    int n;
    timing_cfg = mk_cfg(0, 2, 0, 0);
    pulse(start_req);
    wait_for(0, 1'b1, n);
    pulse(stop_cmd);
    repeat (4) @(negedge clk);
    chk("R7 clk kept", sclk_en, 1);
    chk("R7 cs kept", (cs_n != 2'b11), 1);
    pulse(unit_edge);
    chk("R7 clk off at boundary", sclk_en, 0);
    wait_for(1, 1'b0, n);
    chk("R7 release", n, 4);
    wait_for(2, 1'b0, n);
  endtask

  task automatic t_park_stop();
    int n;
    timing_cfg = mk_cfg(0, 0, 3, 0);
    pulse(start_req);
    wait_for(0, 1'b1, n);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    repeat (3) @(negedge clk);
    pulse(stop_cmd);
    chk("R8 cs still low", (cs_n != 2'b11), 1);
    wait_for(1, 1'b0, n);
    chk("R8 release", n, 5);
    wait_for(2, 1'b0, n);
  endtask

  task automatic t_held();
    int n;
    timing_cfg = mk_cfg(0, 0, 0, 5);
    pulse(start_req);
    wait_for(0, 1'b1, n);
    end_close();
    wait_for(1, 1'b0, n);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    n = 2;
    for (int k = 0; k < 40; k++) begin
      if (cs_n != 2'b11) break;
      chk("R10 busy in gap", busy, 1);
      @(negedge clk);
      n = n + 1;
    end
    chk("R10 reassert", n, 7);
    wait_for(0, 1'b1, n);
    end_close();
    wait_for(2, 1'b0, n);
  endtask

  task automatic t_pick();
    int n;
    timing_cfg = mk_cfg(1, 0, 0, 0);
    cs_pick = 1'b1;
    pulse(start_req);
    cs_pick = 1'b0;
    wait_for(0, 1'b1, n);
    repeat (2) @(negedge clk);
    chk("R4 pick ignored mid", cs_n, 2'b01);
    end_close();
    wait_for(2, 1'b0, n);
  endtask

  initial begin
    rst_n = 1'b0;
    timing_cfg = '0; cs_pick = 1'b0;
    start_req = 1'b0; unit_edge = 1'b0; xfer_end = 1'b0;
    close_flag = 1'b0; stop_cmd = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full("hold wins", mk_cfg(3, 1, 5, 2), 3, 5, 2, 1'b0);
    t_full("trail wins", mk_cfg(1, 6, 2, 4), 1, 6, 4, 1'b1);
    t_full("zero", mk_cfg(0, 0, 0, 0), 0, 0, 0, 1'b0);
    t_full("R2 noise", 32'hF2F3F1F2, 2, 3, 2, 1'b1);
    t_park();
    t_stop();
    t_park_stop();
    t_held();
    t_pick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule